// File: doc/BRIEF.md
# Board Control Status Parity Unit

This block holds the main 16-bit control/status register of a network interface board, together with the logic that records RAM parity errors. The host writes the status register to hold the board in reset, to take the network interface out of loopback, to enable the auxiliary bus and to enable interrupts. It starts the network controller by writing the attention bit first to 1 and then back to 0. Each rising edge of that bit becomes a single-clock pulse on the controller's attention input. The host can also read back strapped configuration bits, including the high address bits it needs to locate the board RAM.

When the RAM reports a parity error, the block records the failing address, the byte lane and the error source, and raises a flag. The flag can drive the bus interrupt. The first error is held and later errors are dropped. The recorded data is freed only when the host writes a 1 to the acknowledge bit. Register access is a plain single-cycle port: writes are sampled on the clock edge and read data is combinational from the selected register.

Top module: `board_csr_unit`

## Requirements
- R1: While status bit 15 is 1, `board_rst` is high. Writing 1 to bit 15 also forces status bits 14, 13, 12, 11 and 5 to 0, whatever values are written to them, for as long as bit 15 stays 1.
- R2: Status bit 14 drives `on_air` and status bit 5 drives `aux_bus_en`. Both are written through offset 0 and take effect on the clock after the write.
- R3: When status bit 13 goes from 0 to 1, `chan_attn` is high for exactly one clock, in the cycle after the write. Rewriting bit 13 as 1, or clearing it, produces no pulse.
- R4: Reading offset 0 returns the following status bits; all other bits read 0.
  - Bit 15: reset.
  - Bit 14: on-air.
  - Bit 13: attention.
  - Bit 12: interrupt enable.
  - Bit 11: parity interrupt enable.
  - Bit 9: parity flag.
  - Bit 8: live `ctrl_irq`.
  - Bit 5: auxiliary bus enable.
  - Bit 4: `strap_big_ram`.
  - Bits [3:0]: `strap_haddr`.
- R5: Writes to the read-only status bits (9, 8, 4, 3:0) and to the unused bits have no effect. Writes to offset 2 and offset 3 have no effect.
- R6: `bus_irq` equals (`ctrl_irq` AND status bit 12) OR (parity flag AND status bit 11).
- R7: A `par_err` pulse in a cycle where the flag is clear sets the flag and records `par_addr_hi`, `par_addr_lo`, `par_lane` and `par_src` on that clock edge.
- R8: While the flag is set, further `par_err` pulses are ignored, and the recorded address, lane and source stay unchanged.
- R9: A write to offset 1 with bit 8 = 1 clears the flag on the next clock. A write with bit 8 = 0 does nothing. If an error and an acknowledge arrive in the same cycle while the flag is clear, the error is recorded.
- R10: Reading offset 1 returns the following, with bit 8 (acknowledge) and all other bits reading 0:
  - Bit 7: source.
  - Bit 6: byte lane.
  - Bits [3:0]: recorded high address.

  Reading offset 2 returns the recorded low 16 address bits.
- R11: Reading offset 3 returns 0.
- R12: An asynchronous low `rst_n` clears every register. After reset all outputs are low and the recorded parity data reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Register write strobe |
| host_addr | input | 2 | Register offset (0 status, 1 parity control, 2 parity address, 3 spare) |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data of the selected register |
| ctrl_irq | input | 1 | Interrupt request from the network controller |
| strap_haddr | input | 4 | Strapped high RAM address bits |
| strap_big_ram | input | 1 | Strap: large RAM devices fitted |
| par_err | input | 1 | Parity error strobe from RAM |
| par_addr_hi | input | 4 | High address bits of the failing access |
| par_addr_lo | input | 16 | Low address bits of the failing access |
| par_lane | input | 1 | Byte lane that failed |
| par_src | input | 1 | Source of the failing access |
| board_rst | output | 1 | Board reset |
| chan_attn | output | 1 | One-clock attention pulse to the controller |
| on_air | output | 1 | Leave loopback |
| aux_bus_en | output | 1 | Auxiliary bus enable |
| bus_irq | output | 1 | Interrupt request to the host bus |

## Verification
The bench builds the block with its default widths: four high address bits and sixteen low address bits. At these widths the high field fills bits [3:0] of both the status strap and the parity control read, so every documented bit position of the register layout is exercised. With sixteen low bits, patterns such as 0xA5C3 and 0x5A3C toggle every bit of the parity address register between first capture and re-capture. These widths also let the bench collide an acknowledge with a fresh error, send an error while the flag is held, and overlap reset with attention.

// File: rtl/board_csr_pkg.sv
package board_csr_pkg;

    typedef enum logic [1:0] {
        REG_STATUS = 2'd0,
        REG_PARCTL = 2'd1,
        REG_PARADR = 2'd2,
        REG_SPARE  = 2'd3
    } reg_sel_e;

    // status register bit positions
    localparam int unsigned BIT_RST   = 15;
    localparam int unsigned BIT_AIR   = 14;
    localparam int unsigned BIT_ATT   = 13;
    localparam int unsigned BIT_IEN   = 12;
    localparam int unsigned BIT_PIEN  = 11;
    localparam int unsigned BIT_PFLAG = 9;
    localparam int unsigned BIT_CIRQ  = 8;
    localparam int unsigned BIT_AUX   = 5;
    localparam int unsigned BIT_BIG   = 4;

    // parity control register bit positions
    localparam int unsigned BIT_ACK   = 8;
    localparam int unsigned BIT_SRC   = 7;
    localparam int unsigned BIT_LANE  = 6;

    typedef struct packed {
        logic rst;
        logic air;
        logic att;
        logic ien;
        logic pien;
        logic aux;
    } ctl_bits_t;

    typedef struct packed {
        ctl_bits_t bits;
        logic      attn_pulse;
    } ctl_state_t;

endpackage

// File: rtl/board_ctl_reg.sv
module board_ctl_reg
    import board_csr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_en,
    input  ctl_bits_t wr_bits,
    output ctl_bits_t ctl,
    output logic      attn_pulse
);

    ctl_state_t st_d, st_q;

    always_comb begin
        st_d            = st_q;
        st_d.attn_pulse = 1'b0;
        if (wr_en) begin
            st_d.bits = wr_bits;
        end
        // reset held: every other control bit is forced off
        if (st_d.bits.rst) begin
            st_d.bits.air  = 1'b0;
            st_d.bits.att  = 1'b0;
            st_d.bits.ien  = 1'b0;
            st_d.bits.pien = 1'b0;
            st_d.bits.aux  = 1'b0;
        end
        st_d.attn_pulse = st_d.bits.att & ~st_q.bits.att;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctl        = st_q.bits;
    assign attn_pulse = st_q.attn_pulse;

endmodule

// File: rtl/board_par_capture.sv
module board_par_capture #(
    parameter int unsigned HI_W = 4,
    parameter int unsigned LO_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            err,
    input  logic [HI_W-1:0] err_hi,
    input  logic [LO_W-1:0] err_lo,
    input  logic            err_lane,
    input  logic            err_src,
    input  logic            ack,
    output logic            flag,
    output logic [HI_W-1:0] cap_hi,
    output logic [LO_W-1:0] cap_lo,
    output logic            cap_lane,
    output logic            cap_src
);

    typedef struct packed {
        logic            flag;
        logic            src;
        logic            lane;
        logic [HI_W-1:0] hi;
        logic [LO_W-1:0] lo;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d = cap_q;
        if (err && !cap_q.flag) begin
            cap_d.flag = 1'b1;
            cap_d.src  = err_src;
            cap_d.lane = err_lane;
            cap_d.hi   = err_hi;
            cap_d.lo   = err_lo;
        end else if (ack) begin
            cap_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign flag     = cap_q.flag;
    assign cap_hi   = cap_q.hi;
    assign cap_lo   = cap_q.lo;
    assign cap_lane = cap_q.lane;
    assign cap_src  = cap_q.src;

endmodule

// File: rtl/board_rd_mux.sv
module board_rd_mux
    import board_csr_pkg::*;
#(
    parameter int unsigned HI_W   = 4,
    parameter int unsigned LO_W   = 16,
    parameter int unsigned DATA_W = 16
) (
    input  reg_sel_e          sel,
    input  ctl_bits_t         ctl,
    input  logic              flag,
    input  logic              cirq,
    input  logic              strap_big,
    input  logic [HI_W-1:0]   strap_hi,
    input  logic              cap_src,
    input  logic              cap_lane,
    input  logic [HI_W-1:0]   cap_hi,
    input  logic [LO_W-1:0]   cap_lo,
    output logic [DATA_W-1:0] rdata
);

    always_comb begin
        rdata = '0;
        unique case (sel)
            REG_STATUS: begin
                rdata[BIT_RST]    = ctl.rst;
                rdata[BIT_AIR]    = ctl.air;
                rdata[BIT_ATT]    = ctl.att;
                rdata[BIT_IEN]    = ctl.ien;
                rdata[BIT_PIEN]   = ctl.pien;
                rdata[BIT_PFLAG]  = flag;
                rdata[BIT_CIRQ]   = cirq;
                rdata[BIT_AUX]    = ctl.aux;
                rdata[BIT_BIG]    = strap_big;
                rdata[HI_W-1:0]   = strap_hi;
            end
            REG_PARCTL: begin
                rdata[BIT_SRC]    = cap_src;
                rdata[BIT_LANE]   = cap_lane;
                rdata[HI_W-1:0]   = cap_hi;
            end
            REG_PARADR: begin
                rdata[LO_W-1:0]   = cap_lo;
            end
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/board_csr_unit.sv
module board_csr_unit
    import board_csr_pkg::*;
#(
    parameter int unsigned HI_W = 4,
    parameter int unsigned LO_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            host_wr,
    input  logic [1:0]      host_addr,
    input  logic [15:0]     host_wdata,
    output logic [15:0]     host_rdata,
    input  logic            ctrl_irq,
    input  logic [HI_W-1:0] strap_haddr,
    input  logic            strap_big_ram,
    input  logic            par_err,
    input  logic [HI_W-1:0] par_addr_hi,
    input  logic [LO_W-1:0] par_addr_lo,
    input  logic            par_lane,
    input  logic            par_src,
    output logic            board_rst,
    output logic            chan_attn,
    output logic            on_air,
    output logic            aux_bus_en,
    output logic            bus_irq
);

    localparam int unsigned DATA_W = 16;

    reg_sel_e        sel;
    logic            wr_status;
    logic            par_ack;
    ctl_bits_t       wr_bits;
    ctl_bits_t       ctl;
    logic            par_flag;
    logic [HI_W-1:0] par_hi;
    logic [LO_W-1:0] par_lo;
    logic            cap_lane;
    logic            cap_src;
    logic            unused_wbits;

    assign sel       = reg_sel_e'(host_addr);
    assign wr_status = host_wr && (sel == REG_STATUS);
    assign par_ack   = host_wr && (sel == REG_PARCTL) && host_wdata[BIT_ACK];

    assign wr_bits.rst  = host_wdata[BIT_RST];
    assign wr_bits.air  = host_wdata[BIT_AIR];
    assign wr_bits.att  = host_wdata[BIT_ATT];
    assign wr_bits.ien  = host_wdata[BIT_IEN];
    assign wr_bits.pien = host_wdata[BIT_PIEN];
    assign wr_bits.aux  = host_wdata[BIT_AUX];

    assign unused_wbits = ^{host_wdata[10:9], host_wdata[7:6], host_wdata[4:0]};

    board_ctl_reg u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_status),
        .wr_bits    (wr_bits),
        .ctl        (ctl),
        .attn_pulse (chan_attn)
    );

    board_par_capture #(
        .HI_W (HI_W),
        .LO_W (LO_W)
    ) u_par (
        .clk      (clk),
        .rst_n    (rst_n),
        .err      (par_err),
        .err_hi   (par_addr_hi),
        .err_lo   (par_addr_lo),
        .err_lane (par_lane),
        .err_src  (par_src),
        .ack      (par_ack),
        .flag     (par_flag),
        .cap_hi   (par_hi),
        .cap_lo   (par_lo),
        .cap_lane (cap_lane),
        .cap_src  (cap_src)
    );

    board_rd_mux #(
        .HI_W   (HI_W),
        .LO_W   (LO_W),
        .DATA_W (DATA_W)
    ) u_rd (
        .sel       (sel),
        .ctl       (ctl),
        .flag      (par_flag),
        .cirq      (ctrl_irq),
        .strap_big (strap_big_ram),
        .strap_hi  (strap_haddr),
        .cap_src   (cap_src),
        .cap_lane  (cap_lane),
        .cap_hi    (par_hi),
        .cap_lo    (par_lo),
        .rdata     (host_rdata)
    );

    assign board_rst  = ctl.rst;
    assign on_air     = ctl.air;
    assign aux_bus_en = ctl.aux;
    assign bus_irq    = (ctrl_irq & ctl.ien) | (par_flag & ctl.pien);

endmodule

// File: rtl/board_csr_chk.sv
module board_csr_chk
    import board_csr_pkg::*;
#(
    parameter int unsigned HI_W = 4,
    parameter int unsigned LO_W = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            host_wr,
    input logic [1:0]      host_addr,
    input logic [15:0]     host_wdata,
    input logic            par_err,
    input logic            chan_attn,
    input logic            board_rst,
    input logic            on_air,
    input logic            aux_bus_en,
    input ctl_bits_t       ctl,
    input logic            par_flag,
    input logic [HI_W-1:0] par_hi,
    input logic [LO_W-1:0] par_lo
);

    logic ack_wr;
    assign ack_wr = host_wr && (host_addr == 2'd1) && host_wdata[BIT_ACK];

    assert_attn_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        chan_attn |=> !chan_attn);

    assert_attn_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
        chan_attn |-> (ctl.att && !$past(ctl.att)));

    assert_reset_forces_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
        board_rst |-> !(on_air || aux_bus_en || ctl.att || ctl.ien || ctl.pien));

    assert_capture_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (par_err && !par_flag) |=> par_flag);

    assert_flag_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (par_flag && !ack_wr) |=> par_flag);

    assert_capture_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (par_flag && $past(par_flag)) |-> ($stable(par_lo) && $stable(par_hi)));

endmodule

bind board_csr_unit board_csr_chk #(
    .HI_W (HI_W),
    .LO_W (LO_W)
) i_board_csr_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr    (host_wr),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .par_err    (par_err),
    .chan_attn  (chan_attn),
    .board_rst  (board_rst),
    .on_air     (on_air),
    .aux_bus_en (aux_bus_en),
    .ctl        (ctl),
    .par_flag   (par_flag),
    .par_hi     (par_hi),
    .par_lo     (par_lo)
);

// File: tb/test_board_csr_unit.sv
module test_board_csr_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [1:0]  host_addr = 2'd0;
    logic [15:0] host_wdata = 16'h0;
    logic [15:0] host_rdata;
    logic        ctrl_irq = 1'b0;
    logic [3:0]  strap_haddr = 4'h9;
    logic        strap_big_ram = 1'b1;
    logic        par_err = 1'b0;
    logic [3:0]  par_addr_hi = 4'h0;
    logic [15:0] par_addr_lo = 16'h0;
    logic        par_lane = 1'b0;
    logic        par_src = 1'b0;
    logic        board_rst, chan_attn, on_air, aux_bus_en, bus_irq;

    int    vectors = 0;
    int    errors = 0;
    string cur_req = "R12";

    always #5 clk = ~clk;

    board_csr_unit i_board_csr_unit (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .ctrl_irq(ctrl_irq),
        .strap_haddr(strap_haddr), .strap_big_ram(strap_big_ram),
        .par_err(par_err), .par_addr_hi(par_addr_hi), .par_addr_lo(par_addr_lo),
        .par_lane(par_lane), .par_src(par_src), .board_rst(board_rst),
        .chan_attn(chan_attn), .on_air(on_air), .aux_bus_en(aux_bus_en),
        .bus_irq(bus_irq)
    );

    // behavioural reference state
    bit       m_rst, m_air, m_att, m_ie, m_pe, m_aux, m_pulse;
    bit       m_flag, m_src, m_lane;
    bit [3:0] m_hi;
    bit [15:0] m_lo;
    bit       n_rst, n_air, n_att, n_ie, n_pe, n_aux;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            {m_rst, m_air, m_att, m_ie, m_pe, m_aux, m_pulse} = '0;
            {m_flag, m_src, m_lane} = '0;
            m_hi = '0;
            m_lo = '0;
        end else begin
            {n_rst, n_air, n_att, n_ie, n_pe, n_aux} = {m_rst, m_air, m_att, m_ie, m_pe, m_aux};
            if (host_wr && host_addr == 2'd0) begin
                n_rst = host_wdata[15]; n_air = host_wdata[14]; n_att = host_wdata[13];
                n_ie  = host_wdata[12]; n_pe  = host_wdata[11]; n_aux = host_wdata[5];
            end
            if (n_rst) {n_air, n_att, n_ie, n_pe, n_aux} = '0;
            m_pulse = n_att && !m_att;
            {m_rst, m_air, m_att, m_ie, m_pe, m_aux} = {n_rst, n_air, n_att, n_ie, n_pe, n_aux};
            if (par_err && !m_flag) begin
                m_flag = 1'b1; m_src = par_src; m_lane = par_lane;
                m_hi = par_addr_hi; m_lo = par_addr_lo;
            end else if (host_wr && host_addr == 2'd1 && host_wdata[8]) begin
                m_flag = 1'b0;
            end
        end
    end

    function automatic logic [15:0] exp_rdata();
        case (host_addr)
            2'd0: return {m_rst, m_air, m_att, m_ie, m_pe, 1'b0, m_flag, ctrl_irq,
                          2'b00, m_aux, strap_big_ram, strap_haddr};
            2'd1: return {8'h00, m_src, m_lane, 2'b00, m_hi};
            2'd2: return m_lo;
            default: return 16'h0;
        endcase
    endfunction

    task automatic chk(input string name, input logic [15:0] act, input logic [15:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", cur_req, name, act, exp);
        end
    endtask

    // compare every clock, away from the active edge
    always @(negedge clk) begin
        chk("host_rdata", host_rdata, exp_rdata());
        chk("board_rst",  16'(board_rst),  16'(m_rst));
        chk("chan_attn",  16'(chan_attn),  16'(m_pulse));
        chk("on_air",     16'(on_air),     16'(m_air));
        chk("aux_bus_en", 16'(aux_bus_en), 16'(m_aux));
        chk("bus_irq",    16'(bus_irq),    16'((ctrl_irq & m_ie) | (m_flag & m_pe)));
    end

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(posedge clk); #1;
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(posedge clk); #1;
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a);
        @(posedge clk); #1;
        host_wr = 1'b0; host_addr = a;
        @(posedge clk); #1;
    endtask

    task automatic perr(input logic [3:0] hi, input logic [15:0] lo, input logic ln, input logic sr);
        @(posedge clk); #1;
        par_err = 1'b1; par_addr_hi = hi; par_addr_lo = lo; par_lane = ln; par_src = sr;
        @(posedge clk); #1;
        par_err = 1'b0;
    endtask

    initial begin
        // R12: reset state
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        rd(2'd0); rd(2'd1); rd(2'd2); rd(2'd3);

        cur_req = "R2";
        wr(2'd0, 16'h4020); rd(2'd0);
        wr(2'd0, 16'h0020); rd(2'd0);

        cur_req = "R3";
        wr(2'd0, 16'h2000);          // rising edge -> pulse
        wr(2'd0, 16'h2000);          // rewrite 1 -> no pulse
        wr(2'd0, 16'h0000);          // clear -> no pulse
        wr(2'd0, 16'h2000); rd(2'd0);
        wr(2'd0, 16'h0000);

        cur_req = "R1";
        wr(2'd0, 16'h7820); rd(2'd0);
        wr(2'd0, 16'hF820); rd(2'd0); // reset with others requested
        wr(2'd0, 16'hE000);           // attention while reset held
        wr(2'd0, 16'h0000); rd(2'd0);

        cur_req = "R5";
        wr(2'd0, 16'h03DF); rd(2'd0);
        wr(2'd2, 16'hFFFF); rd(2'd2);
        wr(2'd3, 16'hFFFF); rd(2'd3);
        cur_req = "R11";
        rd(2'd3);

        cur_req = "R4";
        strap_haddr = 4'h6; strap_big_ram = 1'b0;
        ctrl_irq = 1'b1; rd(2'd0);

        cur_req = "R6";
        wr(2'd0, 16'h1000); rd(2'd0);
        ctrl_irq = 1'b0; rd(2'd0);

        cur_req = "R7";
        wr(2'd0, 16'h0800);
        perr(4'hA, 16'hA5C3, 1'b1, 1'b0);
        cur_req = "R10";
        rd(2'd1); rd(2'd2);

        cur_req = "R8";
        perr(4'h3, 16'h1234, 1'b0, 1'b1);
        rd(2'd1); rd(2'd2);

        cur_req = "R9";
        wr(2'd1, 16'h00FF); rd(2'd0);    // bit 8 clear: no release
        wr(2'd1, 16'h0100); rd(2'd0); rd(2'd1);
        // ack and new error together while flag clear: error wins
        @(posedge clk); #1;
        host_wr = 1'b1; host_addr = 2'd1; host_wdata = 16'h0100;
        par_err = 1'b1; par_addr_hi = 4'h5; par_addr_lo = 16'h5A3C; par_lane = 1'b0; par_src = 1'b1;
        @(posedge clk); #1;
        host_wr = 1'b0; par_err = 1'b0;
        rd(2'd1); rd(2'd2); rd(2'd0);
        wr(2'd1, 16'h0100); rd(2'd0);

        cur_req = "R12";
        @(posedge clk); #1 rst_n = 1'b0;
        @(posedge clk); #1 rst_n = 1'b1;
        rd(2'd0); rd(2'd1); rd(2'd2);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog run did not finish actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule